// File: doc/BRIEF.md
# Receive Byte Queue with Newest-Entry Overwrite

This block holds up to four received bytes between a serial receiver and a register interface. The receiver side offers one byte per cycle through a push strobe, or signals a line break. A break inserts a zero byte and raises a sticky flag that the controller later clears. The register side pops bytes in arrival order. It sees the head byte combinationally while its pop strobe is high.

Two status outputs tell the controller how full the queue is: a data-ready flag and a queue-full flag. An accept output tells the receiver when it may deliver more data. A flush input, driven by the receiver-reset command, discards the whole content in one cycle. When a byte arrives while the queue already holds four bytes, it is not dropped. It replaces the byte written most recently, and the older three are kept.

Top module: `rx_overwrite_fifo`

## Requirements
- R1: Bytes leave through `pop_data` in the order they were accepted; up to DEPTH (4) bytes are held.
- R2: A push into a queue that holds DEPTH bytes, with no pop in that cycle, replaces the most recently written byte, and the occupancy stays at DEPTH.
- R3: `rdy` is 1 after any cycle that accepts a byte. It falls to 0 after the pop that removes the last byte, so it is 1 exactly when at least one byte is held.
- R4: `full` is 1 exactly when DEPTH bytes are held. A pop without a same-cycle push clears it.
- R5: While the queue is empty, `pop_data` reads 0x00, and a pop changes neither the content nor the flags.
- R6: `can_accept` is 1 only when `rx_en` is 1 and `full` is 0.
- R7: `brk_evt` sets `brk_flag` and pushes 0x00 through the push path, including the overwrite rule of R2. `push_data` is ignored in that cycle. `brk_clr` clears `brk_flag`, and a same-cycle `brk_evt` wins over it.
- R8: `flush` empties the queue and clears `rdy` and `full`. Any pop or push in the same cycle has no effect. `brk_flag` is left unchanged.
- R9: When a pop and a push fall in the same cycle, the pop is applied first. A full queue then stays full and loses no byte.
- R10: `pop_data` shows the head byte in the cycle the pop strobe is high, and the next byte appears after the following rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enabled, used only to form `can_accept` |
| push_vld | input | 1 | Receiver delivers `push_data` this cycle |
| push_data | input | DATA_W | Received byte |
| brk_evt | input | 1 | Line break seen; inserts a zero byte |
| pop | input | 1 | Register read of the head byte |
| flush | input | 1 | Receiver reset; empties the queue |
| brk_clr | input | 1 | Clears the sticky break flag |
| pop_data | output | DATA_W | Head byte, or 0 when empty |
| rdy | output | 1 | At least one byte held |
| full | output | 1 | DEPTH bytes held |
| can_accept | output | 1 | Receiver may deliver a byte |
| brk_flag | output | 1 | Sticky break-change flag |

## Verification
The assertions assume that every input is a clean single-cycle-sampled level after reset. They also assume that the register side only takes `pop_data` as meaningful in cycles when `pop` is high. They make no assumption about the receiver honouring `can_accept`: pushes into a full queue are legal and must overwrite. The stimulus therefore mixes pushes, breaks, pops, flushes and clears freely, including against a full queue and an empty queue. All inputs change only at the falling edge.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } q_op_t;

  function automatic int unsigned wrap_inc(int unsigned p, int unsigned lim);
    return (p == lim - 1) ? 0 : p + 1;
  endfunction

  function automatic int unsigned wrap_dec(int unsigned p, int unsigned lim);
    return (p == 0) ? lim - 1 : p - 1;
  endfunction

endpackage

// File: rtl/rxq_ctrl.sv
`timescale 1ns/1ps
module rxq_ctrl #(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rxq_pkg::q_op_t   op,
  output logic             pop_ok,
  output logic [CNT_W-1:0] occ,
  output logic [CNT_W-1:0] occ_mid,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic [PTR_W-1:0] rd_idx
);
  import rxq_pkg::*;

  localparam logic [CNT_W-1:0] OCC_MAX = CNT_W'(DEPTH);

  logic [PTR_W-1:0] head_q, head_n, head_mid, tail_q, tail_n;
  logic [CNT_W-1:0] occ_n;
  logic             upd;

  // pop is applied before push
  always_comb begin
    pop_ok   = op.pop && (occ != '0);
    occ_mid  = occ - CNT_W'(pop_ok);
    head_mid = pop_ok ? PTR_W'(wrap_inc(int'(head_q), DEPTH)) : head_q;
    head_n   = head_mid;
    tail_n   = tail_q;
    occ_n    = occ_mid;
    wr_en    = 1'b0;
    wr_idx   = tail_q;
    if (op.flush) begin
      head_n = '0;
      tail_n = '0;
      occ_n  = '0;
    end else if (op.push) begin
      wr_en = 1'b1;
      if (occ_mid == OCC_MAX) begin
        wr_idx = PTR_W'(wrap_dec(int'(tail_q), DEPTH));
      end else begin
        tail_n = PTR_W'(wrap_inc(int'(tail_q), DEPTH));
        occ_n  = occ_mid + 1'b1;
      end
    end
    upd = op.flush | op.push | pop_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ    <= '0;
    end else if (upd) begin
      head_q <= head_n;
      tail_q <= tail_n;
      occ    <= occ_n;
    end
  end

  assign rd_idx = head_q;

endmodule

// File: rtl/rxq_mem.sv
`timescale 1ns/1ps
module rxq_mem #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (hit) slot[i] <= wr_data;
    end
  end

  assign rd_data = slot[rd_idx];

endmodule

// File: rtl/rxq_flags.sv
`timescale 1ns/1ps
module rxq_flags #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop_ok,
  input  logic [CNT_W-1:0] occ_mid,
  input  logic             brk_evt,
  input  logic             brk_clr,
  output logic             rdy,
  output logic             full,
  output logic             brk_flag
);
  localparam logic [CNT_W-1:0] NEAR_FULL = CNT_W'(DEPTH - 1);

  logic rdy_n, full_n, brk_n;

  always_comb begin
    rdy_n = rdy;
    if (flush)                           rdy_n = 1'b0;
    else if (push)                       rdy_n = 1'b1;
    else if (pop_ok && occ_mid == '0)    rdy_n = 1'b0;

    full_n = full;
    if (flush)                           full_n = 1'b0;
    else if (push && occ_mid >= NEAR_FULL) full_n = 1'b1;
    else if (pop_ok)                     full_n = 1'b0;

    brk_n = brk_flag;
    if (brk_evt)      brk_n = 1'b1;
    else if (brk_clr) brk_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy      <= 1'b0;
      full     <= 1'b0;
      brk_flag <= 1'b0;
    end else begin
      rdy      <= rdy_n;
      full     <= full_n;
      brk_flag <= brk_n;
    end
  end

endmodule

// File: rtl/rx_overwrite_fifo.sv
`timescale 1ns/1ps
module rx_overwrite_fifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              push_vld,
  input  logic [DATA_W-1:0] push_data,
  input  logic              brk_evt,
  input  logic              pop,
  input  logic              flush,
  input  logic              brk_clr,
  output logic [DATA_W-1:0] pop_data,
  output logic              rdy,
  output logic              full,
  output logic              can_accept,
  output logic              brk_flag
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  rxq_pkg::q_op_t    op;
  logic              pop_ok, wr_en;
  logic [CNT_W-1:0]  occ, occ_mid;
  logic [PTR_W-1:0]  wr_idx, rd_idx;
  logic [DATA_W-1:0] wr_word, head_word;

  assign op.push  = push_vld | brk_evt;
  assign op.pop   = pop;
  assign op.flush = flush;
  assign wr_word  = brk_evt ? '0 : push_data;

  rxq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .op(op), .pop_ok(pop_ok), .occ(occ),
    .occ_mid(occ_mid), .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx)
  );

  rxq_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_word),
    .rd_idx(rd_idx), .rd_data(head_word)
  );

  rxq_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(op.push),
    .pop_ok(pop_ok), .occ_mid(occ_mid), .brk_evt(brk_evt),
    .brk_clr(brk_clr), .rdy(rdy), .full(full), .brk_flag(brk_flag)
  );

  assign pop_data   = (occ != '0) ? head_word : '0;
  assign can_accept = rx_en & ~full;

endmodule

// File: rtl/rxq_checker.sv
`timescale 1ns/1ps
module rxq_checker #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              push_vld,
  input logic              brk_evt,
  input logic              pop,
  input logic              flush,
  input logic              brk_clr,
  input logic [DATA_W-1:0] pop_data,
  input logic              rdy,
  input logic              full,
  input logic              can_accept,
  input logic              brk_flag,
  input logic [CNT_W-1:0]  occ
);
  a_r3_rdy_tracks_occ: assert property (@(posedge clk) disable iff (!rst_n)
    rdy == (occ != '0));

  a_r4_full_tracks_occ: assert property (@(posedge clk) disable iff (!rst_n)
    full == (occ == CNT_W'(DEPTH)));

  a_r5_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !rdy) |-> pop_data == '0);

  a_r5_empty_pop_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !rdy && !push_vld && !brk_evt) |=> !rdy && !full);

  a_r6_accept_gate: assert property (@(posedge clk) disable iff (!rst_n)
    can_accept |-> (rx_en && !full));

  a_r2_overwrite_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && (push_vld || brk_evt) && !flush) |=> full);

  a_r7_break_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> brk_flag);

  a_r7_break_pushes: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_evt && !flush) |=> rdy);

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!rdy && !full && occ == '0));

  a_r8_flush_keeps_brk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !brk_evt && !brk_clr) |=> brk_flag == $past(brk_flag));

endmodule

bind rx_overwrite_fifo rxq_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rxq_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .push_vld(push_vld),
  .brk_evt(brk_evt), .pop(pop), .flush(flush), .brk_clr(brk_clr),
  .pop_data(pop_data), .rdy(rdy), .full(full), .can_accept(can_accept),
  .brk_flag(brk_flag), .occ(occ)
);

// File: tb/test_rx_overwrite_fifo.sv
`timescale 1ns/1ps
module test_rx_overwrite_fifo;
  localparam int DEPTH  = 4;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic rx_en, push_vld, brk_evt, pop, flush, brk_clr;
  logic [DATA_W-1:0] push_data;
  logic [DATA_W-1:0] pop_data;
  logic rdy, full, can_accept, brk_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [DATA_W-1:0] mq[$];
  bit m_brk;

  always #2 clk = ~clk;

  rx_overwrite_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_rx_overwrite_fifo (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .push_vld(push_vld),
    .push_data(push_data), .brk_evt(brk_evt), .pop(pop), .flush(flush),
    .brk_clr(brk_clr), .pop_data(pop_data), .rdy(rdy), .full(full),
    .can_accept(can_accept), .brk_flag(brk_flag)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int head_exp();
    return (mq.size() != 0) ? int'(mq[0]) : 0;
  endfunction

  task automatic check_state(string req);
    chk(req, "rdy (R3)", int'(rdy), int'(mq.size() != 0));
    chk(req, "full (R4)", int'(full), int'(mq.size() == DEPTH));
    chk(req, "can_accept (R6)", int'(can_accept), int'(rx_en && mq.size() != DEPTH));
    chk(req, "brk_flag (R7)", int'(brk_flag), int'(m_brk));
    chk(req, "head (R1/R5)", int'(pop_data), head_exp());
  endtask

  // one cycle: drive at falling edge, check head while pop high, update model
  task automatic cyc(string req, bit pu, logic [DATA_W-1:0] d, bit po,
                     bit bk, bit fl, bit cl);
    logic [DATA_W-1:0] w;
    push_vld = pu; push_data = d; pop = po; brk_evt = bk; flush = fl; brk_clr = cl;
    #1;
    if (po) chk(req, "pop_data in pop cycle (R10)", int'(pop_data), head_exp());
    @(posedge clk);
    if (bk) m_brk = 1'b1;
    else if (cl) m_brk = 1'b0;
    if (fl) mq.delete();
    else begin
      if (po && mq.size() != 0) void'(mq.pop_front());
      if (pu || bk) begin
        w = bk ? '0 : d;
        if (mq.size() == DEPTH) mq[DEPTH-1] = w;
        else mq.push_back(w);
      end
    end
    @(negedge clk);
    push_vld = 0; pop = 0; brk_evt = 0; flush = 0; brk_clr = 0;
    check_state(req);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    rst_n = 0; rx_en = 1; push_vld = 0; push_data = '0; brk_evt = 0;
    pop = 0; flush = 0; brk_clr = 0; m_brk = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("reset");

    // R5: pop on empty
    cyc("R5", 0, 8'h00, 1, 0, 0, 0);
    // R1: fill in order
    for (int i = 0; i < DEPTH; i++) cyc("R1", 1, 8'h10 + 8'(i), 0, 0, 0, 0);
    // R2: overwrite newest twice
    cyc("R2", 1, 8'hA5, 0, 0, 0, 0);
    cyc("R2", 1, 8'h5A, 0, 0, 0, 0);
    // R6: receiver disabled
    rx_en = 0; cyc("R6", 0, 8'h00, 0, 0, 0, 0); rx_en = 1;
    // R9: pop and push together while full
    cyc("R9", 1, 8'h77, 1, 0, 0, 0);
    // R7: break while full overwrites with zero, push_data ignored
    cyc("R7", 1, 8'hEE, 0, 1, 0, 0);
    // R10/R1: drain
    for (int i = 0; i < DEPTH + 1; i++) cyc("R10", 0, 8'h00, 1, 0, 0, 0);
    // R7: clear, then clear vs break
    cyc("R7", 0, 8'h00, 0, 0, 0, 1);
    cyc("R7", 0, 8'h00, 0, 1, 0, 1);
    cyc("R7", 0, 8'h00, 0, 0, 0, 1);
    // R8: flush with push, pop and break
    cyc("R8", 1, 8'h33, 0, 0, 0, 0);
    cyc("R8", 1, 8'h44, 1, 1, 1, 0);
    cyc("R8", 0, 8'h00, 0, 0, 1, 0);

    // near-exhaustive sweep of all input combinations against each occupancy
    for (int occ_t = 0; occ_t <= DEPTH; occ_t++) begin
      for (int combo = 0; combo < 64; combo++) begin
        cyc("R8", 0, 8'h00, 0, 0, 1, 0);
        for (int k = 0; k < occ_t; k++) cyc("R1", 1, 8'(occ_t * 16 + k + 1), 0, 0, 0, 0);
        rx_en = combo[5];
        cyc("R9", combo[0], 8'(combo * 3 + 7), combo[1], combo[2], combo[3], combo[4]);
        rx_en = 1;
        while (mq.size() != 0) cyc("R1", 0, 8'h00, 1, 0, 0, 0);
      end
    end

    // pseudo-random mix
    seed = 32'h1F2E3D;
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom(seed + n);
      rx_en = r[9];
      cyc("R2", r[0] | r[1], 8'(r >> 12), r[2] & r[3], r[4] & r[5] & r[6],
          (r[7:8] == 2'b11) & r[10] & r[11], r[20]);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule